// File: doc/BRIEF.md
# HDLC Transmit Pool Handshake Controller

This block holds outgoing bytes for one HDLC channel and releases them under control of the host. The host writes bytes one at a time into a 32-byte pool. It then issues a command that hands the whole pool to a downstream serializer. Bytes leave over a ready/valid byte interface. A flag marks the last byte of a message whenever the command closes the frame.

The host learns that the pool can be written in two ways. It can poll a status bit, or it can wait for a level interrupt. The interrupt has three sources, each with its own mask bit: pool drained, message ended, and rejected command. Reading the interrupt status clears the pending sources. The same read also clears a sticky status bit that records discarded writes. Flag, CRC and bit-stuffing generation sit downstream of this block.

Top module: `hdlcTxPool`

## Requirements
- R1: After reset, `writable` is 1 while `txValid`, `overflow`, `irqPend` and `irq` are all 0.
- R2: While `writable` is 1, up to 32 written bytes are stored, and they leave on `txData` in the order they were written.
- R3: A write is discarded and sets `overflow` in any of three cases: the pool already holds 32 bytes, `writable` is 0, or a command is accepted in the same cycle. `overflow` then stays 1 until an `irqRd` cycle.
- R4: `cmdCode` takes four values: 2'b01 sends a whole frame, 2'b10 continues a frame, 2'b11 ends a frame, and 2'b00 has no effect. A command is accepted when the pool is non-empty and `writable` is 1. In the cycle after an accepted command, `writable` is 0 and `txValid` is 1.
- R5: After code 2'b10, `txLast` is never 1. After codes 2'b01 and 2'b11, `txLast` is 1 only with the final byte of the pool.
- R6: The output byte advances only on a cycle with `txValid` and `txReady` both high. While `txValid` is 1 and `txReady` is 0, `txValid`, `txData` and `txLast` hold.
- R7: In the cycle after the final byte is taken, the pool is empty and `writable` is 1. Pending bit 0 (pool ready) is also set. For codes 2'b01 and 2'b11, pending bit 1 (end of message) is set as well.
- R8: In two cases a non-zero command sends nothing and sets pending bit 2 (command error): the pool is empty, or a transfer is already in progress. The transfer in progress keeps its end-of-message mode.
- R9: `irq` is the OR of the pending bits whose `irqMask` bit is 0. An `irqRd` cycle clears all pending bits and `overflow`, unless one of them is set again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host byte write strobe |
| wrData | input | 8 | Host write byte |
| cmdEn | input | 1 | Command strobe |
| cmdCode | input | 2 | Command code |
| txValid | output | 1 | Byte available to serializer |
| txData | output | 8 | Byte to serializer |
| txLast | output | 1 | Last byte of message |
| txReady | input | 1 | Serializer takes the byte |
| writable | output | 1 | Pool may be written (status bit) |
| overflow | output | 1 | Sticky discarded-write status |
| irqRd | input | 1 | Interrupt status read strobe |
| irqMask | input | 3 | Per-source mask, 1 = masked |
| irqPend | output | 3 | Pending sources: bit 0 ready, bit 1 end of message, bit 2 error |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take three things for granted about the inputs: they hold clean 0/1 levels after reset, a command or a read lasts exactly one cycle, and the serializer may drop `txReady` at any time. The stimulus drives every input just after the active edge and issues at most one command per cycle. It varies `txReady` through fixed four-cycle patterns, so the hold property is exercised under stalls of different lengths. Status reads come only once the events they clear have already settled. The one exception is the same-cycle priority of a set over a read, which the stimulus leaves to the assertions.

// File: rtl/txPoolPkg.sv
package txPoolPkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_FRAME = 2'b01,
    CMD_CONT  = 2'b10,
    CMD_END   = 2'b11
  } txCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic storeByte;
    logic startSend;
    logic advance;
    logic clearPool;
  } poolStrobe_t;

  localparam int IRQ_READY = 0;
  localparam int IRQ_EOM   = 1;
  localparam int IRQ_ERR   = 2;
  localparam int IRQ_NUM   = 3;
endpackage

// File: rtl/txPoolData.sv
module txPoolData
  import txPoolPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  poolStrobe_t   strobe,
  input  logic [DW-1:0] wrData,
  output logic [CW-1:0] fillCount,
  output logic [DW-1:0] rdData,
  output logic          finalByte
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.storeByte) mem[fillCount[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount <= '0;
      rdPtr     <= '0;
    end else begin
      if (strobe.clearPool) begin
        fillCount <= '0;
        rdPtr     <= '0;
      end else begin
        if (strobe.storeByte) fillCount <= fillCount + 1'b1;
        if (strobe.startSend) rdPtr <= '0;
        else if (strobe.advance) rdPtr <= rdPtr + 1'b1;
      end
    end
  end

  assign rdData    = mem[rdPtr[AW-1:0]];
  assign finalByte = (rdPtr == CW'(fillCount - 1'b1));

  // R2: pool never holds more than DEPTH bytes
  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));
endmodule

// File: rtl/txPoolCtrl.sv
module txPoolCtrl
  import txPoolPkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               cmdEn,
  input  logic [1:0]         cmdCode,
  input  logic               txReady,
  input  logic               irqRd,
  input  logic [IRQ_NUM-1:0] irqMask,
  input  logic [CW-1:0]      fillCount,
  input  logic               finalByte,
  output poolStrobe_t        strobe,
  output logic               writable,
  output logic               txValid,
  output logic               txLast,
  output logic               overflow,
  output logic [IRQ_NUM-1:0] irqPend,
  output logic               irq
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  typedef enum logic {ST_FILL, ST_SEND} poolState_e;
  poolState_e state;
  logic lastMode;

  logic cmdValid, accept, cmdBad, wrOk, wrDrop, hand, done;
  logic [IRQ_NUM-1:0] pendSet;

  always_comb begin
    cmdValid = cmdEn && (cmdCode != CMD_NONE);
    accept   = cmdValid && (state == ST_FILL) && (fillCount != '0);
    cmdBad   = cmdValid && !accept;
    wrOk     = wrEn && (state == ST_FILL) && !accept && (fillCount < FULL);
    wrDrop   = wrEn && !wrOk;
    hand     = (state == ST_SEND) && txReady;
    done     = hand && finalByte;

    strobe.storeByte = wrOk;
    strobe.startSend = accept;
    strobe.advance   = hand && !finalByte;
    strobe.clearPool = done;

    pendSet            = '0;
    pendSet[IRQ_READY] = done;
    pendSet[IRQ_EOM]   = done && lastMode;
    pendSet[IRQ_ERR]   = cmdBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_FILL;
      lastMode <= 1'b0;
      overflow <= 1'b0;
      irqPend  <= '0;
    end else begin
      if (accept) begin
        state    <= ST_SEND;
        lastMode <= (cmdCode != CMD_CONT);
      end else if (done) begin
        state <= ST_FILL;
      end
      overflow <= wrDrop | (overflow & ~irqRd);
      irqPend  <= pendSet | (irqPend & {IRQ_NUM{~irqRd}});
    end
  end

  assign writable = (state == ST_FILL);
  assign txValid  = (state == ST_SEND);
  assign txLast   = (state == ST_SEND) && lastMode && finalByte;
  assign irq      = |(irqPend & ~irqMask);

  // R4: accepted command hands the pool to the serializer
  assert_cmd_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (!writable && txValid));
  // R8: rejected command flags an error
  assert_cmd_error_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdBad |=> irqPend[IRQ_ERR]);
  // R3: overflow is sticky until a status read
  assert_no_overflow_loss_R3: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !irqRd) |=> overflow);
  // R7: draining the final byte reopens the pool
  assert_drain_reopen_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (writable && irqPend[IRQ_READY] && (fillCount == '0)));
  // R2: bytes are only offered from a non-empty pool
  assert_valid_nonempty_R2: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (fillCount != '0));
endmodule

// File: rtl/hdlcTxPool.sv
module hdlcTxPool
  import txPoolPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DW-1:0]      wrData,
  input  logic               cmdEn,
  input  logic [1:0]         cmdCode,
  output logic               txValid,
  output logic [DW-1:0]      txData,
  output logic               txLast,
  input  logic               txReady,
  output logic               writable,
  output logic               overflow,
  input  logic               irqRd,
  input  logic [IRQ_NUM-1:0] irqMask,
  output logic [IRQ_NUM-1:0] irqPend,
  output logic               irq
);
  poolStrobe_t   strobe;
  logic [CW-1:0] fillCount;
  logic          finalByte;

  txPoolCtrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cmdEn(cmdEn), .cmdCode(cmdCode),
    .txReady(txReady), .irqRd(irqRd), .irqMask(irqMask),
    .fillCount(fillCount), .finalByte(finalByte), .strobe(strobe),
    .writable(writable), .txValid(txValid), .txLast(txLast),
    .overflow(overflow), .irqPend(irqPend), .irq(irq)
  );

  txPoolData #(.DEPTH(DEPTH), .DW(DW)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .fillCount(fillCount), .rdData(txData), .finalByte(finalByte)
  );

  // R6: a stalled byte holds until taken
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));
endmodule

// File: tb/test_hdlcTxPool.sv
module test_hdlcTxPool;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {len[6:0], cmd[1:0], seed[7:0], readyPattern[3:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {7'd5,  2'b01, 8'h10, 4'b1111},
    {7'd32, 2'b11, 8'hA0, 4'b1010},
    {7'd1,  2'b10, 8'h33, 4'b0110},
    {7'd17, 2'b01, 8'hF0, 4'b1001},
    {7'd32, 2'b10, 8'h01, 4'b1111}
  };
  localparam logic [7:0] STEP = 8'd5;

  logic clk = 0, rstN = 0, wrEn = 0, cmdEn = 0, txReady = 0, irqRd = 0;
  logic [7:0] wrData = '0;
  logic [1:0] cmdCode = '0;
  logic [2:0] irqMask = '0;
  logic txValid, txLast, writable, overflow, irq;
  logic [7:0] txData;
  logic [2:0] irqPend;

  int checks = 0, fails = 0, cycleCnt = 0;
  bit finished = 0;

  hdlcTxPool i_hdlcTxPool (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .cmdEn(cmdEn),
    .cmdCode(cmdCode), .txValid(txValid), .txData(txData), .txLast(txLast),
    .txReady(txReady), .writable(writable), .overflow(overflow), .irqRd(irqRd),
    .irqMask(irqMask), .irqPend(irqPend), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 20000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cycleCnt);
      finishRun();
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeBytes(input int n, input logic [7:0] seed, input logic [7:0] step);
    for (int i = 0; i < n; i++) begin
      wrEn = 1; wrData = 8'(seed + i * step);
      tick();
    end
    wrEn = 0;
  endtask

  task automatic issueCmd(input logic [1:0] c);
    cmdEn = 1; cmdCode = c;
    tick();
    cmdEn = 0; cmdCode = 2'b00;
  endtask

  task automatic readIrq();
    irqRd = 1; tick(); irqRd = 0;
  endtask

  task automatic drain(input int expLen, input bit endMark, input logic [7:0] seed,
                       input logic [7:0] step, input logic [3:0] pat, input string tag);
    int got = 0;
    int cyc = 0;
    bit stallSeen = 0;
    bit dataOk = 1, lastOk = 1, holdOk = 1;
    logic [7:0] stallData = '0;
    logic stallLast = 0;
    while (got < expLen && cyc < 400) begin
      txReady = pat[cyc % 4];
      #1;
      if (stallSeen && !(txValid && txData == stallData && txLast == stallLast)) holdOk = 0;
      if (txValid && txReady) begin
        if (txData != 8'(seed + got * step)) dataOk = 0;
        if (txLast != (endMark && got == expLen - 1)) lastOk = 0;
        got++;
        stallSeen = 0;
      end else if (txValid) begin
        stallSeen = 1; stallData = txData; stallLast = txLast;
      end
      tick();
      cyc++;
    end
    txReady = 0;
    check(got == expLen, {tag, " R2 byte count"}, got, expLen);
    check(dataOk, {tag, " R2 byte order"}, dataOk, 1);
    check(lastOk, {tag, " R5 last marker"}, lastOk, 1);
    check(holdOk, {tag, " R6 stall hold"}, holdOk, 1);
    check(writable && !txValid, {tag, " R7 pool reopened"}, {writable, txValid}, 2'b10);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    check(writable == 1, "R1 writable", writable, 1);
    check(txValid == 0, "R1 txValid", txValid, 0);
    check({overflow, irqPend, irq} == 5'b0, "R1 flags", {overflow, irqPend, irq}, 0);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      int len = int'(VEC[v][20:14]);
      logic [1:0] c = VEC[v][13:12];
      logic [7:0] seed = VEC[v][11:4];
      logic [3:0] pat = VEC[v][3:0];
      writeBytes(len, seed, STEP);
      check(overflow == 0, "R3 no overflow within depth", overflow, 0);
      issueCmd(c);
      check(!writable && txValid, "R4 command accepted", {writable, txValid}, 2'b01);
      drain(len, c != 2'b10, seed, STEP, pat, "vec");
      check(irqPend == ((c != 2'b10) ? 3'b011 : 3'b001), "R7 pending after drain",
            irqPend, (c != 2'b10) ? 3'b011 : 3'b001);
      readIrq();
    end

    // R3 writes beyond depth are dropped
    writeBytes(34, 8'h00, 8'h01);
    check(overflow == 1, "R3 overflow set", overflow, 1);
    issueCmd(2'b01);
    drain(32, 1, 8'h00, 8'h01, 4'b1111, "R3 full pool");
    check(overflow == 1, "R3 overflow sticky", overflow, 1);
    readIrq();
    check(overflow == 0 && irqPend == 0, "R9 read clears", {overflow, irqPend}, 0);

    // R3/R8 write and command while sending
    writeBytes(3, 8'h40, 8'h02);
    issueCmd(2'b10);
    writeBytes(1, 8'hEE, 8'h00);
    check(overflow == 1, "R3 write during send dropped", overflow, 1);
    issueCmd(2'b01);
    check(irqPend[2] == 1, "R8 command during send error", irqPend, 3'b100);
    drain(3, 0, 8'h40, 8'h02, 4'b1100, "R8 continue kept");
    readIrq();

    // R8 command with empty pool
    issueCmd(2'b11);
    check(txValid == 0 && writable == 1, "R8 empty command sends nothing",
          {txValid, writable}, 2'b01);
    check(irqPend == 3'b100, "R8 error pending", irqPend, 3'b100);
    readIrq();

    // R4 no-op code
    writeBytes(2, 8'h77, 8'h11);
    issueCmd(2'b00);
    check(txValid == 0 && writable == 1 && irqPend == 0, "R4 code 00 no effect",
          {txValid, writable, irqPend}, 5'b01000);
    issueCmd(2'b01);
    drain(2, 1, 8'h77, 8'h11, 4'b0101, "R4 after no-op");

    // R9 masking
    irqMask = 3'b011; #1;
    check(irq == 0, "R9 masked sources", irq, 0);
    irqMask = 3'b001; #1;
    check(irq == 1, "R9 unmasked eom", irq, 1);
    irqMask = 3'b110; #1;
    check(irq == 1, "R9 unmasked ready", irq, 1);
    readIrq();
    check(irq == 0 && irqPend == 0, "R9 cleared by read", {irq, irqPend}, 0);

    finishRun();
  end
endmodule